// File: doc/BRIEF.md
# Encrypted Flash Verify Readout

This block forms the byte returned to an external programmer when it reads back program flash for verification. It keeps three small sets of nonvolatile cells: a 64-byte scrambling key, a group of lock bits and a one-byte option word. A verify read of program space either returns the flash byte unchanged or returns its XNOR with one key byte. The XNOR form is used as soon as any key byte holds something other than FFh. When any lock bit is programmed, program-space reads are blocked and return FFh.

A second read space holds the option word. At address 00FCh it shows the watchdog power-up bit in place and ones in every other bit. Reads from the on-chip software path (in-application mode) bypass both locking and scrambling. The flash byte is supplied by the surrounding array in the same cycle as the read strobe. The answer appears on the output one clock later and is held until the next read.

Top module: `flash_verify_readout`

## Requirements
- R1: After reset the output is FFh, every key byte is FFh (scrambling off), all lock bits are 1 (unlocked) and the option word is FFh.
- R2: A read strobe loads the output on the next clock edge; with no strobe the output keeps its value whatever the other inputs do.
- R3: With no key byte different from FFh, an unlocked program-space read (space 0, not in-application) returns the flash byte unchanged.
- R4: Once any key byte differs from FFh, an unlocked program-space read returns ~(flash ^ key[a]), where a is the low 6 bits of the read address, and this stays so until a mass erase.
- R5: A program write to a key byte, the lock bits or the option word can only turn bits from 1 to 0 (new = old AND data); writing FFh changes nothing.
- R6: Mass erase returns all key bytes, lock bits and the option word to all ones and switches scrambling off; it wins over a program write in the same cycle.
- R7: If any lock bit is 0, a program-space read outside in-application mode returns FFh.
- R8: In option space (space 1), address 00FCh returns the option word's bit 3 in bit 3 and 1 in bits 7:4 and 2:0; any other address returns FFh. Lock and key do not affect option reads.
- R9: A program-space read in in-application mode returns the raw flash byte regardless of lock bits and key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Verify read strobe |
| rd_addr_i | input | 16 | Verify read address |
| rd_space_i | input | 1 | 0 program flash, 1 option space |
| iap_mode_i | input | 1 | Read issued by in-application software |
| flash_rdata_i | input | 8 | Flash byte at rd_addr_i |
| key_wr_i | input | 1 | Program strobe for one key byte |
| key_addr_i | input | 6 | Key byte index |
| key_wdata_i | input | 8 | Key program data |
| lock_wr_i | input | 1 | Program strobe for the lock bits |
| lock_wdata_i | input | 3 | Lock program data |
| opt_wr_i | input | 1 | Program strobe for the option word |
| opt_wdata_i | input | 8 | Option program data |
| mass_erase_i | input | 1 | Erase key, lock bits and option word |
| vdata_o | output | 8 | Verify data |

## Verification
A wrong scrambling flag shows on the first program-space read after the offending write: the read returns the plain byte where the XNOR was due, or the reverse. A lost or extra 1-to-0 transition in a key byte shows only on reads whose low address bits select that byte, so reads sweep many addresses after each key change. A lock or option cell that fails to clear or erase shows on the next read of the matching space, one clock after the strobe.

// File: rtl/fvr_pkg.sv
package fvr_pkg;
  typedef enum logic [2:0] {
    SRC_PLAIN,
    SRC_CIPHER,
    SRC_BLOCKED,
    SRC_OPTION,
    SRC_BLANK
  } rd_src_e;
endpackage

// File: rtl/fvr_nv_cell.sv
module fvr_nv_cell #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         prog_i,
  input  logic [W-1:0] prog_data_i,
  input  logic         erase_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      val_q <= '1;
    else if (erase_i) val_q <= '1;
    else if (prog_i)  val_q <= val_q & prog_data_i;
  end

  assign val_o = val_q;

  p_clear_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !erase_i |=> ((val_q & ~$past(val_q)) == '0));

  p_erase_all_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (val_q == '1));
endmodule

// File: rtl/fvr_key_store.sv
module fvr_key_store #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          erase_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o,
  output logic          enc_on_o
);
  logic [W-1:0] key_q [DEPTH];
  logic         enc_q;
  logic [W-1:0] merged;

  assign merged = key_q[waddr_i] & wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) key_q[i] <= '1;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) key_q[i] <= '1;
    end else if (wr_i) begin
      key_q[waddr_i] <= merged;
    end
  end

  // Sticky flag: bits only clear between erases, so one non-FF byte keeps it set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     enc_q <= 1'b0;
    else if (erase_i)                enc_q <= 1'b0;
    else if (wr_i && merged != '1)   enc_q <= 1'b1;
  end

  assign rdata_o  = key_q[raddr_i];
  assign enc_on_o = enc_q;

  p_key_clear_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !erase_i) |=> ((key_q[$past(waddr_i)] & ~$past(key_q[waddr_i])) == '0));

  p_enc_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_q && !erase_i) |=> enc_q);

  p_erase_plain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (!enc_q && key_q[0] == '1));
endmodule

// File: rtl/fvr_read_mux.sv
module fvr_read_mux
  import fvr_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          W        = 8,
  parameter logic [15:0] OPT_ADDR = 16'h00FC,
  parameter int          WDT_BIT  = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              space_i,
  input  logic              iap_i,
  input  logic [W-1:0]      flash_i,
  input  logic [W-1:0]      key_i,
  input  logic              enc_on_i,
  input  logic              locked_i,
  input  logic [W-1:0]      opt_i,
  output logic [W-1:0]      data_o
);
  rd_src_e      src;
  logic [W-1:0] opt_view;

  always_comb begin
    if (space_i)          src = (addr_i == ADDR_W'(OPT_ADDR)) ? SRC_OPTION : SRC_BLANK;
    else if (iap_i)       src = SRC_PLAIN;
    else if (locked_i)    src = SRC_BLOCKED;
    else if (enc_on_i)    src = SRC_CIPHER;
    else                  src = SRC_PLAIN;
  end

  always_comb begin
    opt_view          = '1;
    opt_view[WDT_BIT] = opt_i[WDT_BIT];
  end

  always_comb begin
    unique case (src)
      SRC_PLAIN:  data_o = flash_i;
      SRC_CIPHER: data_o = ~(flash_i ^ key_i);
      SRC_OPTION: data_o = opt_view;
      default:    data_o = '1;
    endcase
  end
endmodule

// File: rtl/flash_verify_readout.sv
module flash_verify_readout #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          KEY_DEPTH = 64,
  parameter int          LOCK_W    = 3,
  parameter logic [15:0] OPT_ADDR  = 16'h00FC,
  parameter int          WDT_BIT   = 3,
  localparam int         KEY_AW    = $clog2(KEY_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rd_space_i,
  input  logic              iap_mode_i,
  input  logic [DATA_W-1:0] flash_rdata_i,
  input  logic              key_wr_i,
  input  logic [KEY_AW-1:0] key_addr_i,
  input  logic [DATA_W-1:0] key_wdata_i,
  input  logic              lock_wr_i,
  input  logic [LOCK_W-1:0] lock_wdata_i,
  input  logic              opt_wr_i,
  input  logic [DATA_W-1:0] opt_wdata_i,
  input  logic              mass_erase_i,
  output logic [DATA_W-1:0] vdata_o
);
  logic [DATA_W-1:0] key_byte;
  logic              enc_on;
  logic [LOCK_W-1:0] lock_bits;
  logic [DATA_W-1:0] opt_word;
  logic [DATA_W-1:0] mux_data;
  logic [DATA_W-1:0] vdata_q;
  logic              locked;

  fvr_key_store #(.DEPTH(KEY_DEPTH), .W(DATA_W)) u_key (
    .clk_i, .rst_ni,
    .wr_i     (key_wr_i),
    .waddr_i  (key_addr_i),
    .wdata_i  (key_wdata_i),
    .erase_i  (mass_erase_i),
    .raddr_i  (rd_addr_i[KEY_AW-1:0]),
    .rdata_o  (key_byte),
    .enc_on_o (enc_on)
  );

  fvr_nv_cell #(.W(LOCK_W)) u_lock (
    .clk_i, .rst_ni,
    .prog_i      (lock_wr_i),
    .prog_data_i (lock_wdata_i),
    .erase_i     (mass_erase_i),
    .val_o       (lock_bits)
  );

  fvr_nv_cell #(.W(DATA_W)) u_opt (
    .clk_i, .rst_ni,
    .prog_i      (opt_wr_i),
    .prog_data_i (opt_wdata_i),
    .erase_i     (mass_erase_i),
    .val_o       (opt_word)
  );

  // Any programmed (zero) lock bit raises the level above 0
  assign locked = ~&lock_bits;

  fvr_read_mux #(.ADDR_W(ADDR_W), .W(DATA_W), .OPT_ADDR(OPT_ADDR), .WDT_BIT(WDT_BIT)) u_mux (
    .addr_i   (rd_addr_i),
    .space_i  (rd_space_i),
    .iap_i    (iap_mode_i),
    .flash_i  (flash_rdata_i),
    .key_i    (key_byte),
    .enc_on_i (enc_on),
    .locked_i (locked),
    .opt_i    (opt_word),
    .data_o   (mux_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vdata_q <= '1;
    else if (rd_en_i) vdata_q <= mux_data;
  end

  assign vdata_o = vdata_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(vdata_o));

  p_plain_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_space_i && !iap_mode_i && !locked && !enc_on)
      |=> (vdata_o == $past(flash_rdata_i)));

  p_lock_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_space_i && !iap_mode_i && locked) |=> (vdata_o == '1));

  p_opt_fill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_space_i) |=> (vdata_o[DATA_W-1:WDT_BIT+1] == '1 && vdata_o[WDT_BIT-1:0] == '1));

  p_iap_raw_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_space_i && iap_mode_i) |=> (vdata_o == $past(flash_rdata_i)));
endmodule

// File: tb/tb_flash_verify_readout.sv
module tb_flash_verify_readout;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_addr = '0;
  logic        rd_space = 1'b0;
  logic        iap = 1'b0;
  logic [7:0]  flash = '0;
  logic        key_wr = 1'b0;
  logic [5:0]  key_addr = '0;
  logic [7:0]  key_wdata = '0;
  logic        lock_wr = 1'b0;
  logic [2:0]  lock_wdata = '0;
  logic        opt_wr = 1'b0;
  logic [7:0]  opt_wdata = '0;
  logic        erase = 1'b0;
  logic [7:0]  vdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] ref_key [64];
  logic [2:0] ref_lock;
  logic [7:0] ref_opt;

  always #10 clk = ~clk;

  flash_verify_readout dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_space_i(rd_space), .iap_mode_i(iap), .flash_rdata_i(flash),
    .key_wr_i(key_wr), .key_addr_i(key_addr), .key_wdata_i(key_wdata),
    .lock_wr_i(lock_wr), .lock_wdata_i(lock_wdata),
    .opt_wr_i(opt_wr), .opt_wdata_i(opt_wdata),
    .mass_erase_i(erase), .vdata_o(vdata)
  );

  function automatic bit ref_enc();
    for (int i = 0; i < 64; i++) if (ref_key[i] != 8'hFF) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] exp_read(logic [15:0] a, logic sp, logic ia, logic [7:0] fd);
    if (sp) return (a == 16'h00FC) ? {4'hF, ref_opt[3], 3'h7} : 8'hFF;
    if (ia) return fd;
    if (ref_lock != 3'b111) return 8'hFF;
    if (ref_enc()) return ~(fd ^ ref_key[a[5:0]]);
    return fd;
  endfunction

  function automatic string exp_tag(logic sp, logic ia);
    if (sp) return "R8";
    if (ia) return "R9";
    if (ref_lock != 3'b111) return "R7";
    if (ref_enc()) return "R4";
    return "R3";
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: vdata=%02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_read(logic [15:0] a, logic sp, logic ia, logic [7:0] fd, string tag = "");
    logic [7:0] e;
    string t;
    e = exp_read(a, sp, ia, fd);
    t = (tag == "") ? exp_tag(sp, ia) : tag;
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a; rd_space = sp; iap = ia; flash = fd;
    @(negedge clk);
    rd_en = 1'b0;
    check(t, vdata, e);
  endtask

  task automatic do_key(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    key_wr = 1'b1; key_addr = a; key_wdata = d;
    @(negedge clk);
    key_wr = 1'b0;
    ref_key[a] &= d;
  endtask

  task automatic do_lock(logic [2:0] d);
    @(negedge clk);
    lock_wr = 1'b1; lock_wdata = d;
    @(negedge clk);
    lock_wr = 1'b0;
    ref_lock &= d;
  endtask

  task automatic do_opt(logic [7:0] d);
    @(negedge clk);
    opt_wr = 1'b1; opt_wdata = d;
    @(negedge clk);
    opt_wr = 1'b0;
    ref_opt &= d;
  endtask

  task automatic do_erase(logic with_key_wr);
    @(negedge clk);
    erase = 1'b1;
    if (with_key_wr) begin key_wr = 1'b1; key_addr = 6'd7; key_wdata = 8'h00; end
    @(negedge clk);
    erase = 1'b0; key_wr = 1'b0;
    for (int i = 0; i < 64; i++) ref_key[i] = 8'hFF;
    ref_lock = 3'b111;
    ref_opt  = 8'hFF;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 64; i++) ref_key[i] = 8'hFF;
    ref_lock = 3'b111;
    ref_opt  = 8'hFF;

    repeat (3) @(negedge clk);
    check("R1", vdata, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", vdata, 8'hFF);
    do_read(16'h0000, 1'b0, 1'b0, 8'h5A, "R1");
    do_read(16'h00FC, 1'b1, 1'b0, 8'h00, "R1");

    for (int i = 0; i < 20; i++)
      do_read(16'($urandom), 1'b0, 1'b0, 8'($urandom), "R3");

    // R2: output holds without strobe
    do_read(16'h1234, 1'b0, 1'b0, 8'hA5, "R2");
    held = vdata;
    @(negedge clk);
    flash = 8'h3C; rd_addr = 16'h0FFF; rd_space = 1'b1; iap = 1'b1;
    repeat (3) @(negedge clk);
    check("R2", vdata, held);
    rd_space = 1'b0; iap = 1'b0;

    do_read(16'h01FC, 1'b1, 1'b0, 8'h00, "R8");
    do_opt(8'h00);
    do_read(16'h00FC, 1'b1, 1'b0, 8'h00, "R8");
    do_opt(8'hFF);
    do_read(16'h00FC, 1'b1, 1'b0, 8'h00, "R5");

    // FFh key write keeps scrambling off
    do_key(6'd5, 8'hFF);
    do_read(16'h0005, 1'b0, 1'b0, 8'h96, "R3");
    do_key(6'd10, 8'h3C);
    do_read(16'h000A, 1'b0, 1'b0, 8'h96, "R4");
    do_read(16'h400A, 1'b0, 1'b0, 8'h00, "R4");
    do_read(16'h0005, 1'b0, 1'b0, 8'h96, "R4");
    do_key(6'd10, 8'hFF);
    do_read(16'h004A, 1'b0, 1'b0, 8'hF0, "R5");
    do_key(6'd63, 8'h81);
    for (int i = 0; i < 16; i++)
      do_read(16'($urandom), 1'b0, 1'b0, 8'($urandom), "R4");
    do_read(16'h000A, 1'b0, 1'b1, 8'h96, "R9");

    do_lock(3'b110);
    do_read(16'h000A, 1'b0, 1'b0, 8'h96, "R7");
    do_read(16'h00FC, 1'b1, 1'b0, 8'h00, "R8");
    do_read(16'h000A, 1'b0, 1'b1, 8'h96, "R9");
    do_lock(3'b111);
    do_read(16'h0003, 1'b0, 1'b0, 8'h11, "R5");

    do_erase(1'b1);
    do_read(16'h0007, 1'b0, 1'b0, 8'h42, "R6");
    do_read(16'h000A, 1'b0, 1'b0, 8'h96, "R6");
    do_read(16'h00FC, 1'b1, 1'b0, 8'h00, "R6");

    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 20);
      if (op < 3)       do_key(6'($urandom), 8'($urandom) | 8'($urandom));
      else if (op == 3) do_lock(3'($urandom) | 3'($urandom));
      else if (op == 4) do_opt(8'($urandom) | 8'($urandom));
      else if (op == 5) do_erase(1'($urandom));
      else begin
        logic [15:0] a;
        a = ($urandom % 4 == 0) ? 16'h00FC : 16'($urandom);
        do_read(a, ($urandom % 6 == 0), ($urandom % 5 == 0), 8'($urandom));
      end
    end

    finish_run();
  end
endmodule